// File: doc/BRIEF.md
# Cross-Point Trim Search Controller

This block runs a slow step-and-wait search that moves a signed trim word toward the point where an external comparator changes state. The block runs from a fast clock. An internal divider makes a control tick every 16·2^k fast cycles. A wait timer then spaces the adjustments 2^W ticks apart. At the end of each wait the comparator input is sampled. A high sample raises the trim by the programmed step and a low sample lowers it. The result is clamped to a window bounded by a positive ceiling and a negative floor.

A run input starts the search and keeps it going. After a programmed number of adjustments the loop stops and holds the trim word, and the done output goes high. Dropping the run input stops the search on the next edge and keeps the trim word where it is. Raising the run input again starts a new search from the held value with a fresh iteration count. The trim word drives an external delay element, and the comparator that senses the result sits outside the block.

Top module: `xpt_trim_ctrl`

## Requirements
- R1: After synchronous reset the trim output is 0, done is 1 and dir_up is 0.
- R2: The control tick period is 16·2^div_exp fast-clock cycles, with div_exp a 4-bit field.
- R3: Consecutive adjustments are 2^wait_exp control ticks apart. The first adjustment lands exactly 16·2^div_exp·2^wait_exp edges after the edge that starts the run.
- R4: At each adjustment the trim changes by step_sel+1, giving a step of 1 to 4. A comparator value of 1 moves the trim up and a value of 0 moves it down.
- R5: The trim is a signed two's-complement word. After any adjustment it lies within [-lower_cfg, +upper_cfg], and a step that would cross a bound stops at that bound.
- R6: A run performs exactly iter_lim+1 adjustments. After the last one, done goes high and the trim is held while run_en stays high.
- R7: dir_up takes the sampled comparator value at each adjustment: 1 when the trim was raised, 0 when it was lowered.
- R8: When run_en is low, the trim does not change and done is 1.
- R9: A rising run_en clears done on the next edge and restarts the iteration count from zero. The held trim is the starting point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Search enable |
| div_exp | input | 4 | Control-clock divide exponent k |
| wait_exp | input | 3 | Wait exponent W, in control ticks |
| step_sel | input | 2 | Step size minus one |
| iter_lim | input | 3 | Adjustment count minus one |
| upper_cfg | input | 6 | Positive trim ceiling |
| lower_cfg | input | 6 | Magnitude of the negative trim floor |
| cmp_in | input | 1 | Comparator result sampled at each adjustment |
| trim_out | output | 7 | Signed trim word |
| dir_up | output | 1 | Direction of the most recent adjustment |
| done | output | 1 | 1 when the loop is not adjusting |

## Verification
The assertions assume that reset starts the trim inside the window and that the bounds do not shrink below the present trim between adjustments. The bench therefore resets before each table vector and holds every configuration field fixed for the whole run. The comparator value is only changed while the run input is low. As a result, every adjustment edge sees the same comparator value, and each final trim and each timing point can be worked out by hand.

// File: rtl/xpt_trim_pkg.sv
package xpt_trim_pkg;
    localparam int BND_W   = 6;
    localparam int TRIM_W  = BND_W + 1;
    localparam int DEXP_W  = 4;
    localparam int WEXP_W  = 3;
    localparam int STEP_W  = 2;
    localparam int ITER_W  = 3;
    localparam int BASE_DIV = 16;
    localparam int EXT_W   = TRIM_W + 2;

    typedef logic signed [TRIM_W-1:0] trim_t;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_WAIT,
        LS_HOLD
    } loop_st_t;

    typedef struct packed {
        logic              raise;
        logic [STEP_W:0]   mag;
        logic [BND_W-1:0]  ceil;
        logic [BND_W-1:0]  floor_mag;
    } step_req_t;

    function automatic trim_t clamp_step(trim_t cur, step_req_t rq);
        logic signed [EXT_W-1:0] c_ext;
        logic signed [EXT_W-1:0] m_ext;
        logic signed [EXT_W-1:0] cand;
        logic signed [EXT_W-1:0] hi_s;
        logic signed [EXT_W-1:0] lo_s;
        c_ext = $signed({{(EXT_W-TRIM_W){cur[TRIM_W-1]}}, cur});
        m_ext = $signed({{(EXT_W-STEP_W-1){1'b0}}, rq.mag});
        hi_s  = $signed({{(EXT_W-BND_W){1'b0}}, rq.ceil});
        lo_s  = -$signed({{(EXT_W-BND_W){1'b0}}, rq.floor_mag});
        cand  = rq.raise ? (c_ext + m_ext) : (c_ext - m_ext);
        if (cand > hi_s)
            cand = hi_s;
        if (cand < lo_s)
            cand = lo_s;
        return cand[TRIM_W-1:0];
    endfunction
endpackage

// File: rtl/xpt_tick_div.sv
module xpt_tick_div
    import xpt_trim_pkg::*;
#(
    parameter int BASE = BASE_DIV,
    parameter int EW   = DEXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [EW-1:0] exp_k,
    output logic          tick
);
    localparam int CNT_W = $clog2(BASE) + (1 << EW) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic [CNT_W:0]   last_w;
    logic [CNT_W-1:0] last;

    always_comb begin
        period = (CNT_W+1)'(BASE) << exp_k;
        last_w = period - 1'b1;
        last   = last_w[CNT_W-1:0];
        tick   = (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the divided tick never lasts two fast cycles in a row
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/xpt_wait_tmr.sv
module xpt_wait_tmr
    import xpt_trim_pkg::*;
#(
    parameter int WW = WEXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [WW-1:0] exp_w,
    output logic          expire
);
    localparam int CNT_W = (1 << WW) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   limit;

    always_comb begin
        span   = (CNT_W+1)'(1) << exp_w;
        limit  = span - 1'b1;
        expire = tick && ({1'b0, cnt_q} >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (expire)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/xpt_trim_reg.sv
module xpt_trim_reg
    import xpt_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adj,
    input  step_req_t req,
    output trim_t     trim_q,
    output logic      dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= '0;
            dir_q  <= 1'b0;
        end else if (adj) begin
            trim_q <= clamp_step(trim_q, req);
            dir_q  <= req.raise;
        end
    end

    // R5: each adjustment leaves the trim inside the window
    p_trim_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        adj |=> (trim_q <= $signed({1'b0, $past(req.ceil)})) &&
                (trim_q >= -$signed({1'b0, $past(req.floor_mag)})));

    // R7: the direction bit follows the sampled comparator
    p_dir_follows_r7: assert property (@(posedge clk) disable iff (rst)
        adj |=> dir_q == $past(req.raise));
endmodule

// File: rtl/xpt_trim_ctrl.sv
module xpt_trim_ctrl
    import xpt_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [DEXP_W-1:0] div_exp,
    input  logic [WEXP_W-1:0] wait_exp,
    input  logic [STEP_W-1:0] step_sel,
    input  logic [ITER_W-1:0] iter_lim,
    input  logic [BND_W-1:0]  upper_cfg,
    input  logic [BND_W-1:0]  lower_cfg,
    input  logic              cmp_in,
    output logic [TRIM_W-1:0] trim_out,
    output logic              dir_up,
    output logic              done
);
    loop_st_t          st_q;
    logic [ITER_W-1:0] iter_q;
    logic              active;
    logic              tick;
    logic              expire;
    logic              adj;
    step_req_t         req;
    trim_t             trim_w;

    always_comb begin
        active        = run_en && (st_q == LS_WAIT);
        adj           = active && expire;
        req.raise     = cmp_in;
        req.mag       = {1'b0, step_sel} + 1'b1;
        req.ceil      = upper_cfg;
        req.floor_mag = lower_cfg;
        done          = (st_q != LS_WAIT);
        trim_out      = trim_w;
    end

    xpt_tick_div u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (!active),
        .exp_k (div_exp),
        .tick  (tick)
    );

    xpt_wait_tmr u_wait (
        .clk    (clk),
        .rst    (rst),
        .clear  (!active),
        .tick   (tick),
        .exp_w  (wait_exp),
        .expire (expire)
    );

    xpt_trim_reg u_trim (
        .clk    (clk),
        .rst    (rst),
        .adj    (adj),
        .req    (req),
        .trim_q (trim_w),
        .dir_q  (dir_up)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LS_IDLE;
            iter_q <= '0;
        end else if (!run_en) begin
            st_q   <= LS_IDLE;
        end else begin
            unique case (st_q)
                LS_IDLE: begin
                    st_q   <= LS_WAIT;
                    iter_q <= '0;
                end
                LS_WAIT: begin
                    if (adj) begin
                        if (iter_q >= iter_lim)
                            st_q <= LS_HOLD;
                        else
                            iter_q <= iter_q + 1'b1;
                    end
                end
                default: st_q <= LS_HOLD;
            endcase
        end
    end

    // R8: with the run input low the trim cannot move
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(trim_out));

    // R6: no change while done is reported
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(trim_out));
endmodule

// File: tb/xpt_trim_ctrl_test.sv
module xpt_trim_ctrl_test;
    import xpt_trim_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_en = 1'b0;
    logic [DEXP_W-1:0] div_exp = '0;
    logic [WEXP_W-1:0] wait_exp = '0;
    logic [STEP_W-1:0] step_sel = '0;
    logic [ITER_W-1:0] iter_lim = '0;
    logic [BND_W-1:0]  upper_cfg = '0;
    logic [BND_W-1:0]  lower_cfg = '0;
    logic              cmp_in = 1'b0;
    logic [TRIM_W-1:0] trim_out;
    logic              dir_up;
    logic              done;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xpt_trim_ctrl uut (
        .clk(clk), .rst(rst), .run_en(run_en), .div_exp(div_exp),
        .wait_exp(wait_exp), .step_sel(step_sel), .iter_lim(iter_lim),
        .upper_cfg(upper_cfg), .lower_cfg(lower_cfg), .cmp_in(cmp_in),
        .trim_out(trim_out), .dir_up(dir_up), .done(done)
    );

    typedef struct packed {
        logic [3:0]        k;
        logic [2:0]        w;
        logic [1:0]        s;
        logic [2:0]        n;
        logic [5:0]        hi;
        logic [5:0]        lo;
        logic              c;
        logic signed [7:0] exp_trim;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 3'd0, 2'd0, 3'd3, 6'd10, 6'd10, 1'b1,  8'sd4},
        '{4'd0, 3'd1, 2'd3, 3'd7, 6'd5,  6'd10, 1'b1,  8'sd5},
        '{4'd1, 3'd0, 2'd1, 3'd2, 6'd10, 6'd3,  1'b0, -8'sd3},
        '{4'd0, 3'd2, 2'd2, 3'd0, 6'd20, 6'd20, 1'b0, -8'sd3},
        '{4'd0, 3'd0, 2'd3, 3'd4, 6'd63, 6'd63, 1'b1,  8'sd20}
    };

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int expv);
        n_chk++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    function automatic int trim_i();
        return int'($signed(trim_out));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        adv(3);
        rst = 1'b0;
        adv(1);
        // R1: reset state
        chk("R1 trim", trim_i(), 0);
        chk("R1 done", int'(done), 1);
        chk("R1 dir", int'(dir_up), 0);

        // Table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            int dur;
            rst = 1'b1;
            adv(1);
            rst = 1'b0;
            div_exp   = VECS[i].k;
            wait_exp  = VECS[i].w;
            step_sel  = VECS[i].s;
            iter_lim  = VECS[i].n;
            upper_cfg = VECS[i].hi;
            lower_cfg = VECS[i].lo;
            cmp_in    = VECS[i].c;
            adv(1);
            dur = (int'(VECS[i].n) + 1) * (16 << VECS[i].k) * (1 << VECS[i].w);
            run_en = 1'b1;
            adv(1);
            adv(dur - 1);
            chk("R2/R3 still running before last step", int'(done), 0);
            adv(1);
            chk("R6 done after iter_lim+1 steps", int'(done), 1);
            chk("R4/R5 final trim", trim_i(), int'(VECS[i].exp_trim));
            chk("R7 direction", int'(dir_up), int'(VECS[i].c));
            adv(20);
            chk("R6 trim held", trim_i(), int'(VECS[i].exp_trim));
            run_en = 1'b0;
            adv(1);
        end

        // R3: first adjustment at exactly 16*2^k*2^W edges (k=1, W=1 -> 64)
        rst = 1'b1;
        adv(1);
        rst = 1'b0;
        div_exp = 4'd1; wait_exp = 3'd1; step_sel = 2'd0; iter_lim = 3'd7;
        upper_cfg = 6'd63; lower_cfg = 6'd63; cmp_in = 1'b1;
        run_en = 1'b1;
        adv(1);
        adv(63);
        chk("R3 no step before window", trim_i(), 0);
        adv(1);
        chk("R3 first step at window", trim_i(), 1);
        run_en = 1'b0;
        adv(1);

        // R8 / R9: stop mid-run and restart
        rst = 1'b1;
        adv(1);
        rst = 1'b0;
        div_exp = 4'd0; wait_exp = 3'd0; step_sel = 2'd0; iter_lim = 3'd7;
        upper_cfg = 6'd63; lower_cfg = 6'd63; cmp_in = 1'b1;
        run_en = 1'b1;
        adv(1);
        adv(32);
        chk("R9 two steps taken", trim_i(), 2);
        run_en = 1'b0;
        adv(40);
        chk("R8 trim held while stopped", trim_i(), 2);
        chk("R8 done while stopped", int'(done), 1);
        run_en = 1'b1;
        adv(1);
        chk("R9 done cleared on restart", int'(done), 0);
        adv(127);
        chk("R9 fresh count still running", int'(done), 0);
        adv(1);
        chk("R9 full count from held value", trim_i(), 10);
        chk("R9 done after restart", int'(done), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule